// File: doc/BRIEF.md
# Boundary Scan Chain with Output Bus Override

This block is a chain of scan cells placed around a device's parallel I/O. Each cell pairs a capture/shift flip-flop with an update latch. A test access port controller outside the block sends three strobes and a two-bit mode code. The capture strobe loads the pin values into the chain. The shift strobe moves the chain one step from serial input to serial output. The update strobe copies the chain into the update latches.

One cell in the chain is internal and is not tied to any pin. Its update latch sets the output bus enable while external test mode is active. A separate high-impedance sampling mode turns the bus off whatever that cell holds. In functional and sampling modes the core drives the pins unchanged. The chain length follows from the I/O count, and the position of the control cell is a parameter.

Top module: `bscan_chain`

## Requirements
- R1: While reset is asserted, every chain stage and every update latch clears to 0. After reset, `scan_out` is 0, and in external test mode `pad_oe` is 0 and `pad_out` is all zero.
- R2: Chain bit `CTRL_POS` is the control cell. I/O signal i sits at chain bit i when i < `CTRL_POS` and at bit i+1 otherwise. When `capture_en` is high and the mode is not idle, on the next clock each I/O stage loads `pin_in[i]` and the control stage loads `core_oe`.
- R3: When `shift_en` is high, `capture_en` is low and the mode is not idle, on each clock every stage takes the value of the next higher bit. The top bit (`LEN-1`) takes `scan_in`. `scan_out` always shows chain bit 0.
- R4: When capture and shift are requested in the same cycle, capture wins.
- R5: The update latches load the chain contents only on a clock where `update_en` is high and the mode is not idle. At all other times they hold their value, including through capture and shift.
- R6: An update in the same cycle as a shift or a capture stores the chain contents as they were before that clock edge.
- R7: In mode 2'b00 (sample/preload) and mode 2'b11 (idle), `pad_out` equals `core_out` and `pad_oe` equals `core_oe`, with no delay.
- R8: In mode 2'b01 (external test), `pad_out[i]` equals the update latch of I/O i, and `pad_oe` equals the update latch of the control cell (1 = drive).
- R9: In mode 2'b10 (high-Z sample), `pad_oe` is 0 whatever the control latch holds. `pad_out` follows `core_out`, and capture and shift keep working.
- R10: In mode 2'b11 (idle), all three strobes are ignored. Chain and latches keep their contents, and a later shift-out returns the old chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| mode_sel | input | 2 | 00 sample/preload, 01 external test, 10 high-Z sample, 11 idle |
| scan_in | input | 1 | Serial data into the top chain bit |
| scan_out | output | 1 | Serial data from chain bit 0 |
| pin_in | input | NUM_IO | Values observed at the I/O ring |
| core_out | input | NUM_IO | Core output data toward the pins |
| core_oe | input | 1 | Core output bus enable |
| pad_out | output | NUM_IO | Output data driven to the pads |
| pad_oe | output | 1 | Output bus enable to the pads |

## Verification
Two pairs of operations can fall in the same cycle: update with shift, and capture with shift. The bench asserts both strobes of a pair on one clock. For update with shift, it then switches to external test mode and reads the latches on `pad_out`/`pad_oe`. These must show the chain as it was before the edge. For capture with shift, it shifts the chain out on `scan_out`, which must show the captured pin values and not the shifted bit. A behavioural model follows every clock, and the same-cycle cases also occur at random during a long mixed-strobe run.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
    typedef enum logic [1:0] {
        BS_SAMPLE = 2'b00,
        BS_EXTEST = 2'b01,
        BS_HIGHZ  = 2'b10,
        BS_IDLE   = 2'b11
    } bs_mode_e;
endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic sh_en,
    input  logic upd_en,
    input  logic cap_d,
    input  logic ser_d,
    output logic stage_q,
    output logic latch_q
);
    // capture has priority over shift; latch samples pre-edge stage value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            if (cap_en)
                stage_q <= cap_d;
            else if (sh_en)
                stage_q <= ser_d;
            if (upd_en)
                latch_q <= stage_q;
        end
    end
endmodule

// File: rtl/bscan_out_ctrl.sv
module bscan_out_ctrl
    import bscan_pkg::*;
#(
    parameter int NUM_IO = 8
) (
    input  bs_mode_e          mode,
    input  logic [NUM_IO-1:0] core_out,
    input  logic              core_oe,
    input  logic [NUM_IO-1:0] upd_io,
    input  logic              upd_ctl,
    output logic [NUM_IO-1:0] pad_out,
    output logic              pad_oe
);
    always_comb begin
        unique case (mode)
            BS_EXTEST: begin
                pad_out = upd_io;
                pad_oe  = upd_ctl;
            end
            BS_HIGHZ: begin
                pad_out = core_out;
                pad_oe  = 1'b0;
            end
            BS_SAMPLE, BS_IDLE: begin
                pad_out = core_out;
                pad_oe  = core_oe;
            end
            default: begin
                pad_out = core_out;
                pad_oe  = core_oe;
            end
        endcase
    end
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int NUM_IO   = 8,
    parameter int CTRL_POS = NUM_IO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic [1:0]        mode_sel,
    input  logic              scan_in,
    output logic              scan_out,
    input  logic [NUM_IO-1:0] pin_in,
    input  logic [NUM_IO-1:0] core_out,
    input  logic              core_oe,
    output logic [NUM_IO-1:0] pad_out,
    output logic              pad_oe
);
    localparam int LEN = NUM_IO + 1;

    bs_mode_e          mode;
    logic              chain_live;
    logic [LEN-1:0]    cap_vec;
    logic [LEN-1:0]    ser_vec;
    logic [LEN-1:0]    chain_q;
    logic [LEN-1:0]    upd_q;
    logic [NUM_IO-1:0] upd_io;

    assign mode       = bs_mode_e'(mode_sel);
    assign chain_live = (mode != BS_IDLE);

    // I/O i occupies chain bit i below the control cell, i+1 above it
    for (genvar i = 0; i < NUM_IO; i++) begin : g_map
        localparam int BIT = (i < CTRL_POS) ? i : i + 1;
        assign cap_vec[BIT] = pin_in[i];
        assign upd_io[i]    = upd_q[BIT];
    end
    assign cap_vec[CTRL_POS] = core_oe;

    for (genvar k = 0; k < LEN; k++) begin : g_cell
        if (k == LEN - 1) begin : g_top
            assign ser_vec[k] = scan_in;
        end else begin : g_mid
            assign ser_vec[k] = chain_q[k+1];
        end
        bscan_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_en  (capture_en & chain_live),
            .sh_en   (shift_en & chain_live),
            .upd_en  (update_en & chain_live),
            .cap_d   (cap_vec[k]),
            .ser_d   (ser_vec[k]),
            .stage_q (chain_q[k]),
            .latch_q (upd_q[k])
        );
    end

    assign scan_out = chain_q[0];

    bscan_out_ctrl #(.NUM_IO(NUM_IO)) u_out (
        .mode     (mode),
        .core_out (core_out),
        .core_oe  (core_oe),
        .upd_io   (upd_io),
        .upd_ctl  (upd_q[CTRL_POS]),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk
    import bscan_pkg::*;
#(
    parameter int NUM_IO   = 8,
    parameter int CTRL_POS = NUM_IO
) (
    input logic              clk,
    input logic              rst_n,
    input logic              capture_en,
    input logic              shift_en,
    input logic              update_en,
    input logic [1:0]        mode_sel,
    input logic [NUM_IO-1:0] core_out,
    input logic              core_oe,
    input logic [NUM_IO-1:0] pad_out,
    input logic              pad_oe,
    input logic [NUM_IO:0]   chain_q,
    input logic [NUM_IO:0]   upd_q
);
    localparam int LEN = NUM_IO + 1;

    AST_HIZ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == BS_HIGHZ) |-> !pad_oe); // R9

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == BS_SAMPLE || mode_sel == BS_IDLE)
            |-> (pad_out == core_out && pad_oe == core_oe)); // R7

    AST_EXTEST_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == BS_EXTEST) |-> (pad_oe == upd_q[CTRL_POS])); // R8

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(update_en && mode_sel != BS_IDLE) |=> $stable(upd_q)); // R5

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == BS_IDLE) |=> $stable(chain_q)); // R10

    AST_CAPTURE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && mode_sel != BS_IDLE)
            |=> (chain_q[CTRL_POS] == $past(core_oe))); // R4

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !capture_en && mode_sel != BS_IDLE)
            |=> (chain_q[LEN-2:0] == $past(chain_q[LEN-1:1]))); // R3
endmodule

bind bscan_chain bscan_chain_chk #(.NUM_IO(NUM_IO), .CTRL_POS(CTRL_POS)) chk_i (.*);

// File: tb/bscan_chain_tb_top.sv
`timescale 1ns/1ps
module bscan_chain_tb_top;
    localparam int N   = 8;
    localparam int CP  = 3;
    localparam int LEN = N + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic capture_en = 0, shift_en = 0, update_en = 0;
    logic [1:0] mode_sel = 2'b01;
    logic scan_in = 0;
    logic scan_out;
    logic [N-1:0] pin_in = '0, core_out = '0;
    logic core_oe = 0;
    logic [N-1:0] pad_out;
    logic pad_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    bscan_chain #(.NUM_IO(N), .CTRL_POS(CP)) dut_i (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .mode_sel(mode_sel), .scan_in(scan_in),
        .scan_out(scan_out), .pin_in(pin_in), .core_out(core_out),
        .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // behavioural reference
    bit    m_chain[LEN];
    bit    m_upd[LEN];
    string so_tag = "R1";

    function automatic int bitpos(int i);
        return (i < CP) ? i : i + 1;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_chain[k]) begin m_chain[k] = 0; m_upd[k] = 0; end
            so_tag = "R1";
        end else if (mode_sel != 2'b11) begin
            bit nc[LEN];
            if (update_en) foreach (m_upd[k]) m_upd[k] = m_chain[k];
            foreach (nc[k]) nc[k] = m_chain[k];
            if (capture_en) begin
                for (int i = 0; i < N; i++) nc[bitpos(i)] = pin_in[i];
                nc[CP] = core_oe;
            end else if (shift_en) begin
                for (int k = 0; k < LEN; k++) nc[k] = (k == LEN-1) ? scan_in : m_chain[k+1];
            end
            foreach (nc[k]) m_chain[k] = nc[k];
            if (capture_en && shift_en) so_tag = "R4";
            else if (capture_en) so_tag = "R2";
            else if (shift_en && update_en) so_tag = "R6";
            else so_tag = "R3";
        end else if (capture_en || shift_en || update_en) begin
            so_tag = "R10";
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [N-1:0] eo;
            logic eoe;
            string ptag;
            case (mode_sel)
                2'b01: begin
                    for (int i = 0; i < N; i++) eo[i] = m_upd[bitpos(i)];
                    eoe = m_upd[CP]; ptag = "R5 R8";
                end
                2'b10: begin eo = core_out; eoe = 1'b0; ptag = "R9"; end
                default: begin eo = core_out; eoe = core_oe; ptag = "R7"; end
            endcase
            chk(so_tag, 32'(scan_out), 32'(m_chain[0]));
            chk(ptag, 32'(pad_out), 32'(eo));
            chk(ptag, 32'(pad_oe), 32'(eoe));
        end
    end

    task automatic drive(bit c, bit s, bit u, logic [1:0] m, bit si);
        @(negedge clk);
        capture_en = c; shift_en = s; update_en = u; mode_sel = m; scan_in = si;
    endtask

    task automatic shift_word(logic [1:0] m, logic [LEN-1:0] pat);
        for (int k = 0; k < LEN; k++) drive(0, 1, 0, m, pat[k]);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", 32'(scan_out), 0);
        chk("R1", 32'(pad_oe), 0);
        chk("R1", 32'(pad_out), 0);

        // R2 capture, R3 concurrent shift-out/preload-in, R5 update
        pin_in = 8'hA5; core_out = 8'h3C; core_oe = 1;
        drive(1, 0, 0, 2'b00, 0);
        shift_word(2'b00, 9'h16B);
        drive(0, 0, 1, 2'b00, 0);
        drive(0, 0, 0, 2'b01, 0);
        drive(0, 0, 0, 2'b01, 0);
        // R4 capture and shift together
        pin_in = 8'h0F; core_oe = 0;
        drive(1, 1, 0, 2'b00, 1);
        shift_word(2'b00, 9'h0F0);
        // R6 shift and update together, viewed under external test
        drive(0, 1, 1, 2'b01, 1);
        drive(0, 0, 0, 2'b01, 0);
        // R9 high-Z with chain active
        drive(1, 0, 0, 2'b10, 0);
        drive(0, 1, 0, 2'b10, 1);
        drive(0, 0, 0, 2'b10, 0);
        // R10 idle ignores strobes
        pin_in = 8'hFF; core_oe = 1;
        drive(1, 1, 1, 2'b11, 1);
        drive(1, 0, 1, 2'b11, 0);
        drive(0, 0, 0, 2'b01, 0);
        shift_word(2'b00, 9'h000);
        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            pin_in = N'($urandom); core_out = N'($urandom); core_oe = 1'($urandom);
            drive(1'($urandom % 4 == 0), 1'($urandom), 1'($urandom % 3 == 0),
                  2'($urandom), 1'($urandom));
        end
        drive(0, 0, 0, 2'b00, 0);
        @(negedge clk); #2;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule